// File: doc/BRIEF.md
# Protected Glitch-Free Clock Prescaler

This block takes the fast, undivided clock of a chip and delivers a divided clock for the CPU and its synchronous peripherals. The ratio is a power of two from 1 to 256 and is picked by a 4-bit select field in an 8-bit control register. Software cannot change that field with a single store. It first writes the unlock value `0x80`. This opens a short window, and `unlockOpen` shows it is open. The next write with bit 7 clear then carries the new select. The window closes by itself after four cycles of the reference strobe `cycTick`.

The divider counts on the fast clock. The output is one high pulse per divided period, a high half of the fast clock gated through a falling-edge-registered enable, so the output cannot glitch. A new ratio is never applied in the middle of a period. The period already running finishes at its old length, and the reload at its end uses the new length. Every period the output shows is therefore either the old or the new one. Readback always returns the ratio actually in force, not the one waiting for the next boundary.

Top module: `clkPrescaler`

## Requirements
- R1: After the asynchronous reset, `rdData` reads 0x00 and `unlockOpen` is low. One fast cycle after reset is released, `clkDiv` starts pulsing once in every fast cycle (divide by 1).
- R2: `rdData` is {window bit (bit 7), 3'b000 (bits 6:4), active select (bits 3:0)}. Bits 6:4 always read zero and are ignored on writes.
- R3: A write of exactly 0x80 sets `unlockOpen` from the next cycle. No other value opens the window.
- R4: While the window is open, each cycle with `cycTick` high counts one tick. `unlockOpen` falls at the edge that counts the fourth tick. A select write on that same edge is still accepted. A new 0x80 write restarts the count.
- R5: A write with bit 7 clear while `unlockOpen` is high takes bits 3:0 as the pending select and closes the window at the same edge.
- R6: A write with bit 7 clear while `unlockOpen` is low is ignored. The active select and the output period stay unchanged.
- R7: Select codes 0 to 8 divide by 2^code (1 to 256). Codes 9 to 15 divide by 1 and still read back as written.
- R8: Rising edges of `clkDiv` are spaced exactly the active ratio in fast cycles apart. `clkDiv` is high only while `clkFast` is high.
- R9: After a select is accepted, the period in progress completes at the old length. If an output pulse starts on the very edge the write is accepted, the period beginning at that pulse is also old. All later periods have the new length. No period of any other length appears.
- R10: The active select in `rdData[3:0]` changes only at the period boundary where the new length starts.
- R11: A write with bit 7 set and any other bit set neither opens the window nor, while it is open, closes it or changes the select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkFast | input | 1 | Undivided fast clock; all logic runs on it |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Control register write strobe |
| wrData | input | 8 | Control register write data |
| cycTick | input | 1 | Cycle reference strobe that times the unlock window |
| rdData | output | 8 | Control register readback |
| unlockOpen | output | 1 | High while the unlock window is open |
| clkDiv | output | 1 | Divided output clock |

## Verification
The bench goes after the edges of the unlock window. A select written on the fourth tick must land and one written a cycle later must not. A design whose window is off by one accepts the late write, rejects the early one, or keeps `unlockOpen` high for too long. The bench also times each output period against the ratio it expects. It switches between ratio 1 and ratio 256 and around reserved codes. It also accepts writes on the very edge where a pulse starts. A switch applied mid-period would show up as a short or odd-length period, and one applied a boundary late would show up as an extra old-length period. Garbage writes with bit 7 set, and select writes while the window is closed, must leave the period and the readback untouched. A design that decodes too loosely would reopen the window or change the ratio.

// File: rtl/clkPrescalerPkg.sv
package clkPrescalerPkg;
  localparam int SEL_W = 4;

  typedef struct packed {
    logic             loadSel;
    logic [SEL_W-1:0] selVal;
  } ctrlStrobe_t;
endpackage

// File: rtl/clkPrescalerCtrl.sv
module clkPrescalerCtrl
  import clkPrescalerPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int WIN_TICKS = 4
) (
  input  logic              clkFast,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cycTick,
  output logic              ceBit,
  output ctrlStrobe_t       strobe
);
  localparam int WIN_W = $clog2(WIN_TICKS + 1);
  localparam logic [DATA_W-1:0] UNLOCK_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [WIN_W-1:0] winCnt;
  logic             selWrite;
  logic             unlockWrite;

  assign selWrite    = wrEn && ceBit && !wrData[DATA_W-1];
  assign unlockWrite = wrEn && (wrData == UNLOCK_CODE);

  always_ff @(posedge clkFast or negedge rstN) begin
    if (!rstN) begin
      ceBit  <= 1'b0;
      winCnt <= '0;
    end else if (selWrite) begin
      ceBit  <= 1'b0;
      winCnt <= '0;
    end else if (unlockWrite) begin
      ceBit  <= 1'b1;
      winCnt <= WIN_W'(WIN_TICKS);
    end else if (ceBit && cycTick) begin
      if (winCnt == WIN_W'(1)) ceBit <= 1'b0;
      winCnt <= winCnt - 1'b1;
    end
  end

  always_comb begin
    strobe.loadSel = selWrite;
    strobe.selVal  = wrData[SEL_W-1:0];
  end
endmodule

// File: rtl/clkPrescalerDp.sv
module clkPrescalerDp
  import clkPrescalerPkg::*;
#(
  parameter int MAX_SHIFT = 8
) (
  input  logic             clkFast,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  output logic [SEL_W-1:0] activeSel,
  output logic [SEL_W-1:0] pendSel,
  output logic             clkDiv
);
  localparam int CNT_W   = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;
  localparam int N_CODES = 2 ** SEL_W;

  logic [CNT_W-1:0] reloadTab [N_CODES];
  logic [CNT_W-1:0] phase;
  logic             phaseEnd;
  logic             gateEn;

  for (genvar i = 0; i < N_CODES; i++) begin : g_tab
    if (i <= MAX_SHIFT) begin : g_pow
      assign reloadTab[i] = CNT_W'((32'd1 << i) - 32'd1);
    end else begin : g_rsv
      assign reloadTab[i] = '0;
    end
  end

  assign phaseEnd = (phase == '0);

  always_ff @(posedge clkFast or negedge rstN) begin
    if (!rstN) begin
      phase     <= '0;
      pendSel   <= '0;
      activeSel <= '0;
    end else begin
      if (strobe.loadSel) pendSel <= strobe.selVal;
      if (phaseEnd) begin
        phase     <= reloadTab[pendSel];
        activeSel <= pendSel;
      end else begin
        phase <= phase - 1'b1;
      end
    end
  end

  always_ff @(negedge clkFast or negedge rstN) begin
    if (!rstN) gateEn <= 1'b0;
    else       gateEn <= phaseEnd;
  end

  assign clkDiv = clkFast & gateEn;
endmodule

// File: rtl/clkPrescaler.sv
module clkPrescaler
  import clkPrescalerPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int WIN_TICKS = 4,
  parameter int MAX_SHIFT = 8
) (
  input  logic              clkFast,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cycTick,
  output logic [DATA_W-1:0] rdData,
  output logic              unlockOpen,
  output logic              clkDiv
);
  ctrlStrobe_t      strobe;
  logic             ceBit;
  logic [SEL_W-1:0] activeSel;
  logic [SEL_W-1:0] pendSel;

  clkPrescalerCtrl #(.DATA_W(DATA_W), .WIN_TICKS(WIN_TICKS)) u_ctrl (
    .clkFast(clkFast), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .cycTick(cycTick), .ceBit(ceBit), .strobe(strobe)
  );

  clkPrescalerDp #(.MAX_SHIFT(MAX_SHIFT)) u_dp (
    .clkFast(clkFast), .rstN(rstN), .strobe(strobe),
    .activeSel(activeSel), .pendSel(pendSel), .clkDiv(clkDiv)
  );

  assign rdData     = {ceBit, {(DATA_W-1-SEL_W){1'b0}}, activeSel};
  assign unlockOpen = ceBit;
endmodule

// File: rtl/clkPrescalerChk.sv
module clkPrescalerChk
  import clkPrescalerPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int WIN_TICKS = 4
) (
  input logic              clkFast,
  input logic              rstN,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic              cycTick,
  input logic [DATA_W-2:0] rdLow,
  input logic              unlockOpen,
  input logic [SEL_W-1:0]  pendSel
);
  localparam logic [DATA_W-1:0] UNLOCK_CODE = {1'b1, {(DATA_W-1){1'b0}}};
  localparam int TC_W = $clog2(WIN_TICKS + 2);

  logic [TC_W-1:0] tickCnt;

  always_ff @(posedge clkFast or negedge rstN) begin
    if (!rstN) tickCnt <= '0;
    else if (wrEn && wrData == UNLOCK_CODE) tickCnt <= '0;
    else if (unlockOpen && cycTick && tickCnt <= TC_W'(WIN_TICKS)) tickCnt <= tickCnt + 1'b1;
  end

  p_rsvd_zero_r2: assert property (@(posedge clkFast) disable iff (!rstN)
    rdLow[DATA_W-2:SEL_W] == '0);

  p_unlock_src_r3: assert property (@(posedge clkFast) disable iff (!rstN)
    $rose(unlockOpen) |-> ($past(wrEn) && $past(wrData) == UNLOCK_CODE));

  p_window_len_r4: assert property (@(posedge clkFast) disable iff (!rstN)
    unlockOpen |-> tickCnt < TC_W'(WIN_TICKS));

  p_window_close_r4: assert property (@(posedge clkFast) disable iff (!rstN)
    (unlockOpen && cycTick && !wrEn && tickCnt == TC_W'(WIN_TICKS - 1)) |=> !unlockOpen);

  p_accept_r5: assert property (@(posedge clkFast) disable iff (!rstN)
    (wrEn && unlockOpen && !wrData[DATA_W-1]) |=>
      (!unlockOpen && pendSel == $past(wrData[SEL_W-1:0])));

  p_reject_r6: assert property (@(posedge clkFast) disable iff (!rstN)
    (wrEn && !unlockOpen && !wrData[DATA_W-1]) |=> pendSel == $past(pendSel));

  p_active_from_pend_r10: assert property (@(posedge clkFast) disable iff (!rstN)
    !$stable(rdLow[SEL_W-1:0]) |-> rdLow[SEL_W-1:0] == $past(pendSel));

  p_garbage_r11: assert property (@(posedge clkFast) disable iff (!rstN)
    (wrEn && wrData[DATA_W-1] && wrData != UNLOCK_CODE) |=> pendSel == $past(pendSel));
endmodule

bind clkPrescaler clkPrescalerChk #(.DATA_W(DATA_W), .WIN_TICKS(WIN_TICKS)) u_chk (
  .clkFast(clkFast), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
  .cycTick(cycTick), .rdLow(rdData[DATA_W-2:0]), .unlockOpen(unlockOpen),
  .pendSel(pendSel)
);

// File: tb/clkPrescaler_bench.sv
`timescale 1ns/1ps
module clkPrescaler_bench;
  logic       clkFast = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       cycTick = 1'b1;
  logic [7:0] rdData;
  logic       unlockOpen;
  logic       clkDiv;

  int compared = 0;
  int mismatched = 0;
  bit started = 1'b0;
  bit done = 1'b0;
  bit tickRandom = 1'b0;

  int cyc = 0;
  int lastPulse = -1;
  int expRatio = 1;
  bit mOpen = 1'b0;
  int mCnt = 0;
  logic [3:0] mPend = 4'd0;
  logic [3:0] mPendOld = 4'd0;
  logic [3:0] mActive = 4'd0;
  int mPendCyc = -1;

  clkPrescaler u_clkPrescaler (
    .clkFast(clkFast), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .cycTick(cycTick), .rdData(rdData), .unlockOpen(unlockOpen), .clkDiv(clkDiv)
  );

  always #5 clkFast = ~clkFast;

  function automatic int ratioOf(input logic [3:0] s);
    return (s <= 4'd8) ? (1 << s) : 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clkFast) cycTick = tickRandom ? 1'($urandom % 2) : 1'b1;

  always @(negedge clkFast) begin
    #2;
    if (started && !done) chk(clkDiv == 1'b0, "R8 low half", int'(clkDiv), 0);
  end

  always @(posedge clkFast) begin
    #2;
    if (started && !done) begin
      logic [3:0] sel;
      cyc++;
      if (wrEn && mOpen && !wrData[7]) begin
        mPendOld = mPend; mPend = wrData[3:0]; mPendCyc = cyc; mOpen = 1'b0;
      end else if (wrEn && wrData == 8'h80) begin
        mOpen = 1'b1; mCnt = 4;
      end else if (mOpen && cycTick) begin
        if (mCnt == 1) mOpen = 1'b0;
        mCnt--;
      end
      if (clkDiv) begin
        sel = (mPendCyc < cyc) ? mPend : mPendOld;
        if (lastPulse >= 0)
          chk(cyc - lastPulse == expRatio, "R7 R8 R9 period", cyc - lastPulse, expRatio);
        mActive = sel;
        expRatio = ratioOf(sel);
        lastPulse = cyc;
      end
      chk(rdData == {mOpen, 3'b000, mActive}, "R2 R10 readback", int'(rdData),
          int'({mOpen, 3'b000, mActive}));
      chk(unlockOpen == mOpen, "R3 R4 R5 R11 window", int'(unlockOpen), int'(mOpen));
    end
  end

  task automatic wrReg(input logic [7:0] d);
    @(negedge clkFast); wrEn = 1'b1; wrData = d;
    @(negedge clkFast); wrEn = 1'b0; wrData = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clkFast);
  endtask

  task automatic probe();
    @(posedge clkFast); #3;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    int seedDummy;
    int pulses;
    seedDummy = int'($urandom(32'h5eed1234));
    #23;
    chk(rdData == 8'h00, "R1 reset readback", int'(rdData), 0);
    chk(unlockOpen == 1'b0, "R1 reset window", int'(unlockOpen), 0);
    @(posedge clkFast); #2;
    rstN = 1'b1; started = 1'b1;
    idle(2);
    pulses = 0;
    for (int i = 0; i < 8; i++) begin
      probe();
      if (clkDiv) pulses++;
    end
    chk(pulses == 8, "R1 divide by one after reset", pulses, 8);

    wrReg(8'h80); wrReg(8'h03); idle(40);
    probe(); chk(rdData[3:0] == 4'd3, "R5 accepted select", int'(rdData[3:0]), 3);

    wrReg(8'h80); idle(2); wrReg(8'h02); idle(30);
    probe(); chk(rdData[3:0] == 4'd2, "R4 write on fourth tick", int'(rdData[3:0]), 2);

    wrReg(8'h80); idle(3); wrReg(8'h05); idle(30);
    probe(); chk(rdData[3:0] == 4'd2, "R4 R6 late write ignored", int'(rdData[3:0]), 2);

    wrReg(8'h06); idle(100);
    probe(); chk(rdData[3:0] == 4'd2, "R6 closed write ignored", int'(rdData[3:0]), 2);

    wrReg(8'h81);
    probe(); chk(unlockOpen == 1'b0, "R11 garbage does not open", int'(unlockOpen), 0);
    wrReg(8'h80); wrReg(8'h83);
    probe(); chk(unlockOpen == 1'b1, "R11 garbage does not close", int'(unlockOpen), 1);
    wrReg(8'h74); idle(30);
    probe(); chk(rdData == 8'h04, "R2 bits 6:4 ignored", int'(rdData), 4);

    wrReg(8'h80); wrReg(8'h0C); idle(20);
    probe(); chk(rdData[3:0] == 4'd12, "R7 reserved code reads back", int'(rdData[3:0]), 12);

    wrReg(8'h80); wrReg(8'h08); idle(600);
    probe(); chk(rdData[3:0] == 4'd8, "R7 max ratio", int'(rdData[3:0]), 8);
    wrReg(8'h80); wrReg(8'h00); idle(300);
    wrReg(8'h80); wrReg(8'h04); idle(60);

    tickRandom = 1'b1;
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 4);
      if (op == 0 || op == 1) begin
        logic [3:0] code;
        code = ($urandom % 8 == 0) ? 4'($urandom % 16) : 4'($urandom % 5);
        wrReg(8'h80);
        idle(int'($urandom % 7));
        wrReg({1'b0, 3'($urandom), code});
      end else if (op == 2) begin
        wrReg(8'($urandom));
      end else begin
        idle(int'($urandom % 40));
      end
    end
    tickRandom = 1'b0;
    wrReg(8'h80); wrReg(8'h01); idle(600);
    probe(); chk(rdData[3:0] == 4'd1, "R9 final switch", int'(rdData[3:0]), 1);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1'b1;
      compared++; mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule